// File: doc/BRIEF.md
# Dual-Channel High/Low Tick PWM

This peripheral drives two PWM output pins. Each channel builds its waveform from two independent 16-bit tick counts. The output is high for the high count, then low for the low count, and the pattern repeats. A channel's tick comes from one of four clock-enable strobes that arrive at the block. A 7-bit prescaler divides the chosen strobe, so one tick occurs every (divider+1) strobe pulses.

Software programs the block through a word-addressed register interface with a single-cycle write strobe and a combinational read port. Each channel has its own count register. One shared control register holds the enable, clock enable, divider and source select of both channels.

Each channel runs a three-state machine:
- `ST_OFF`: output low, waiting to run.
- `ST_HIGH`: output high, counting high ticks.
- `ST_LOW`: output low, counting low ticks.

The machine has these transitions:
- **start**: from `ST_OFF`, when the channel begins to run. It latches both counts and enters `ST_HIGH`, or `ST_LOW` if the high count is zero.
- **high_done**: from `ST_HIGH` to `ST_LOW`, after the last high tick when the low count is non-zero.
- **boundary**: from the end of a period back into `ST_HIGH` or `ST_LOW`. It latches fresh counts, and it also fires at the end of a high phase when the low count is zero.
- **stop**: from any state to `ST_OFF`, whenever the channel stops running.

Top module: `dual_hl_pwm`

## Requirements
- R1: Byte offset 0x0 holds the channel 0 counts and offset 0x4 holds the channel 1 counts, with the high count in bits [31:16] and the low count in bits [15:0]. Offset 0x8 is the control register. Writes store data, and reads return the last written value. Control bits outside mask 0x00FFFFF3 read as zero, and offset 0xC reads as zero.
- R2: Control bits select when a channel runs. Bit 0 enables channel 0 and bit 1 enables channel 1. Bit 15 is the channel 0 clock enable and bit 23 is the channel 1 clock enable. A channel runs only when both its enable and its clock enable are set. While it runs, its output is high for H ticks and then low for L ticks, repeating, where H and L are its counts.
- R3: The prescaler sits in bits [14:8] for channel 0 and bits [22:16] for channel 1. With divider value D, one tick occurs every D+1 pulses of the selected strobe.
- R4: The source select sits in bits [5:4] for channel 0 and bits [7:6] for channel 1. Value S picks `tick_src[S]`, and the other strobes have no effect on that channel.
- R5: A low count of zero gives a constant high output, and a high count of zero gives a constant low output.
- R6: Clearing a channel's enable drives its output low in the cycle right after the write edge, even in the middle of a period.
- R7: When a channel goes from stopped to running, its output is still low in the cycle after the write. It goes high one cycle later, because each new waveform begins with the high phase.
- R8: A count register write does not change the phase in progress. The new counts apply from the next period boundary.
- R9: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tick_src | input | 4 | Four clock-enable strobes that a channel can select |
| pwm_out | output | 2 | PWM output, one bit per channel |

## Verification
The waveform is measured in steady state with several inputs:
- Different high/low count pairs, which catches swapped or off-by-one phases.
- A divider of 2 on an always-on strobe, which separates the prescaler from the counters.
- A strobe that pulses every other cycle, which shows that the chosen source is really the one used.
- An unused strobe that never pulses, which must freeze the output high.

Other inputs cover the corner cases:
- Zero counts, which give constant levels.
- A write in the middle of the high phase, which must leave the current low phase at its old length.
- Disable and re-enable, with the output sampled on the exact cycles after each write.

// File: rtl/hl_pwm_pkg.sv
package hl_pwm_pkg;
    localparam int NUM_CH    = 2;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int DIV_W     = 7;
    localparam int SEL_W     = 2;
    localparam int NUM_SRC   = 1 << SEL_W;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } phase_e;

    function automatic int en_bit(input int ch);
        return ch;
    endfunction
    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction
    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction
    function automatic int clken_bit(input int ch);
        return 15 + 8 * ch;
    endfunction
endpackage

// File: rtl/hl_pwm_regs.sv
module hl_pwm_regs
    import hl_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NUM_CH-1:0][DATA_W-1:0] cnt_regs,
    output logic [DATA_W-1:0]        ctrl_reg
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_regs <= '0;
            ctrl_reg <= '0;
        end else if (wr_en) begin
            if (word == WORD_W'(NUM_CH))
                ctrl_reg <= wdata & CTRL_MASK;
            else if (word < WORD_W'(NUM_CH))
                cnt_regs[word[0]] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (word == WORD_W'(NUM_CH))
            rdata = ctrl_reg;
        else if (word < WORD_W'(NUM_CH))
            rdata = cnt_regs[word[0]];
    end

    // R1: bits outside the mask never hold a one
    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg & ~CTRL_MASK) == '0);
    // R1: a count write is stored as given
    a_r1_count_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == '0) |=> cnt_regs[0] == $past(wdata));
endmodule

// File: rtl/hl_pwm_prescale.sv
module hl_pwm_prescale
    import hl_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DIV_W-1:0]   div,
    input  logic [NUM_SRC-1:0] src,
    output logic               tick
);
    logic [DIV_W-1:0] pc_q;
    logic             strobe;

    assign strobe = src[sel];
    assign tick   = run && strobe && (pc_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (!run)
            pc_q <= '0;
        else if (strobe)
            pc_q <= tick ? '0 : pc_q + DIV_W'(1);
    end

    // R3: the divider count restarts after every tick
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pc_q == '0);
    // R3: the count is cleared while the channel is stopped
    a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pc_q == '0);
endmodule

// File: rtl/hl_pwm_phase_fsm.sv
module hl_pwm_phase_fsm
    import hl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             pwm_out
);
    phase_e           state_q, state_d;
    logic [CNT_W-1:0] ctr_q, ctr_d;
    logic [CNT_W-1:0] hi_q, hi_d;
    logic [CNT_W-1:0] lo_q, lo_d;
    logic             start;

    always_comb begin
        state_d = state_q;
        ctr_d   = ctr_q;
        hi_d    = hi_q;
        lo_d    = lo_q;
        start   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (run) start = 1'b1;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (ctr_q == hi_q - CNT_W'(1)) begin
                        if (lo_q == '0) begin
                            start = 1'b1;
                        end else begin
                            state_d = ST_LOW;
                            ctr_d   = '0;
                        end
                    end else begin
                        ctr_d = ctr_q + CNT_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (lo_q == '0 || ctr_q == lo_q - CNT_W'(1))
                        start = 1'b1;
                    else
                        ctr_d = ctr_q + CNT_W'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
        if (start) begin
            hi_d    = hi_cnt;
            lo_d    = lo_cnt;
            ctr_d   = '0;
            state_d = (hi_cnt == '0) ? ST_LOW : ST_HIGH;
        end
        if (!run) begin
            state_d = ST_OFF;
            ctr_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            ctr_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            ctr_q   <= ctr_d;
            hi_q    <= hi_d;
            lo_q    <= lo_d;
        end
    end

    always_comb begin
        pwm_out = (state_q == ST_HIGH) && run;
    end

    // R6: a stopped channel is off on the next cycle
    a_r6_stop_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state_q == ST_OFF);
    // R7: a running channel leaves the off state at once
    a_r7_leave_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && run) |=> state_q != ST_OFF);
    // R2: the high-phase counter stays below the latched count
    a_r2_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HIGH |-> ctr_q < hi_q);
    // R5: with a zero low count the high phase never ends
    a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && lo_q == '0 && hi_cnt != '0 && run)
        |=> state_q == ST_HIGH);
endmodule

// File: rtl/dual_hl_pwm.sv
module dual_hl_pwm
    import hl_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0]  tick_src,
    output logic [NUM_CH-1:0]   pwm_out
);
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_regs;
    logic [DATA_W-1:0]             ctrl_reg;

    hl_pwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cnt_regs (cnt_regs),
        .ctrl_reg (ctrl_reg)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic run;
        logic tick;
        assign run = ctrl_reg[en_bit(ch)] && ctrl_reg[clken_bit(ch)];

        hl_pwm_prescale u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .sel   (ctrl_reg[sel_lsb(ch) +: SEL_W]),
            .div   (ctrl_reg[div_lsb(ch) +: DIV_W]),
            .src   (tick_src),
            .tick  (tick)
        );

        hl_pwm_phase_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .tick    (tick),
            .hi_cnt  (cnt_regs[ch][DATA_W-1 -: CNT_W]),
            .lo_cnt  (cnt_regs[ch][CNT_W-1:0]),
            .pwm_out (pwm_out[ch])
        );
    end
endmodule

// File: tb/dual_hl_pwm_test.sv
module dual_hl_pwm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tick_src = 4'b0011;
    logic [1:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    ch;
        int    hi;
        int    lo;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    dual_hl_pwm uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_src(tick_src), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick_src[2] = ~tick_src[2];
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic wait_level(input int ch, input logic v);
        for (int i = 0; i < 3000 && pwm_out[ch] !== v; i++) @(negedge clk);
    endtask

    // driver side: queue what the requirements predict
    task automatic expect_wave(input int ch, input int hi, input int lo, input string tag);
        exp_t e;
        e.ch = ch; e.hi = hi; e.lo = lo; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor side: measure one steady period and compare with the queue head
    task automatic monitor_wave();
        exp_t e;
        int nh, nl;
        e = exp_q.pop_front();
        @(negedge clk);
        wait_level(e.ch, 1'b0); wait_level(e.ch, 1'b1);
        wait_level(e.ch, 1'b0); wait_level(e.ch, 1'b1);
        nh = 0; nl = 0;
        while (pwm_out[e.ch] === 1'b1 && nh < 3000) begin nh++; @(negedge clk); end
        while (pwm_out[e.ch] === 1'b0 && nl < 3000) begin nl++; @(negedge clk); end
        check({e.tag, " high"}, nh, e.hi);
        check({e.tag, " low"}, nl, e.lo);
    endtask

    task automatic hold_check(input int ch, input logic v, input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== v) bad++;
        end
        check(tag, bad, 0);
    endtask

    initial begin
        int nl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9 outputs", pwm_out, 0);
        rd_check(4'h0, 32'h0, "R9 count0");
        rd_check(4'h4, 32'h0, "R9 count1");
        rd_check(4'h8, 32'h0, "R9 ctrl");

        // R1: readback, mask, unused offset
        wr(4'h8, 32'hFFFF_FFFF);
        rd_check(4'h8, 32'h00FF_FFF3, "R1 ctrl mask");
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0003_0005);
        wr(4'h4, 32'h1234_ABCD);
        rd_check(4'h0, 32'h0003_0005, "R1 count0");
        rd_check(4'h4, 32'h1234_ABCD, "R1 count1");
        rd_check(4'hC, 32'h0, "R1 unused offset");

        // R2: enable without clock enable stays low
        wr(4'h8, 32'h0000_0001);
        hold_check(0, 1'b0, 20, "R2 gated by clock enable");
        wr(4'h8, 32'h0000_8001);
        expect_wave(0, 3, 5, "R2 ch0 3/5");
        monitor_wave();

        // R3: divider 2 on an always-on strobe
        wr(4'h4, 32'h0002_0004);
        wr(4'h8, 32'h0082_8043);
        expect_wave(1, 6, 12, "R3 ch1 div2");
        monitor_wave();

        // R4: select the every-other-cycle strobe
        wr(4'h4, 32'h0002_0003);
        wr(4'h8, 32'h0080_8083);
        expect_wave(1, 4, 6, "R4 ch1 src2");
        monitor_wave();
        // R4: silent strobe freezes the start level
        wr(4'h8, 32'h0000_8001);
        wr(4'h8, 32'h0080_80C3);
        @(negedge clk);
        hold_check(1, 1'b1, 30, "R4 ch1 src3 frozen");

        // R6: disable in the middle of a high phase
        wait_level(0, 1'b0); wait_level(0, 1'b1);
        wr(4'h8, 32'h0080_80C2);
        check("R6 immediate low", pwm_out[0], 0);
        hold_check(0, 1'b0, 10, "R6 stays low");

        // R7: re-enable starts with the high phase
        wr(4'h8, 32'h0080_80C3);
        check("R7 low one cycle after write", pwm_out[0], 0);
        @(negedge clk);
        check("R7 high on next cycle", pwm_out[0], 1);

        // R8: count write during the high phase waits for the boundary
        wait_level(0, 1'b0); wait_level(0, 1'b1);
        wr(4'h0, 32'h0004_0002);
        wait_level(0, 1'b0);
        nl = 0;
        while (pwm_out[0] === 1'b0 && nl < 3000) begin nl++; @(negedge clk); end
        check("R8 old low kept", nl, 5);
        expect_wave(0, 4, 2, "R8 new counts");
        monitor_wave();

        // R5: zero counts give constant levels
        wr(4'h0, 32'h0005_0000);
        repeat (20) @(negedge clk);
        hold_check(0, 1'b1, 30, "R5 low count zero");
        wr(4'h0, 32'h0000_0005);
        repeat (20) @(negedge clk);
        hold_check(0, 1'b0, 30, "R5 high count zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule